// File: doc/BRIEF.md
# Floating-point compare condition unit

This unit compares two IEEE-754 operands and produces one boolean condition bit for a floating-point condition-code register. Both operands are either single-precision or double-precision, chosen by a format input. The pair is sorted into one of three relations: below, same value, or unordered. A 4-bit predicate mask then picks which of those relations make the condition true. An optional absolute-value mode clears both sign bits before the comparison.

Each accepted compare returns, one clock later, the condition bit, the condition-code index it targets, a one-hot write mask for that index and an invalid-operation status bit. The status is reported on every compare, including compares that raise nothing. The control/status register logic can therefore clear its cause field when invalid is low. Arithmetic on the operands, apart from clearing the sign, is not done here, and denormals are compared exactly as encoded.

Top module: `fp_cmp_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero.
- R2: `fmt_dbl_i`=0 selects single format, where only the low 1+SP_EXP_W+SP_FRAC_W bits of each operand bus are used and the upper bits have no effect. `fmt_dbl_i`=1 selects double format over the whole bus. In both formats the sign is the top bit of the used field, the exponent lies below it and the fraction is in the least significant bits.
- R3: An operand is a NaN when its exponent is all ones and its fraction is non-zero. If either operand is a NaN, the pair is unordered and neither below nor equal.
- R4: `res_invalid_o` is 1 only for an unordered pair, and then exactly when `pred_i[3]`=1 or either operand is a signalling NaN (a NaN whose most significant fraction bit is 0).
- R5: +0 and -0 compare equal. Equal takes precedence, so an equal pair is never below.
- R6: Non-NaN operands are ordered by sign and magnitude. A negative value is below a positive one, larger magnitudes are more extreme, and infinities order as the extreme values.
- R7: `res_bit_o` = (`pred_i[2]` & below) | (`pred_i[1]` & equal) | (`pred_i[0]` & unordered).
- R8: With `abs_i`=1 both signs are treated as 0 before the comparison. NaN detection is unchanged.
- R9: `res_valid_o` is `valid_i` delayed by exactly one clock, and the results belong to the inputs of that cycle.
- R10: On a valid result, `res_cc_o` is the `cc_i` of the compare, and `cc_wmask_o` has exactly one bit set, at position `cc_i`.
- R11: In a cycle with `valid_i`=0, `res_bit_o`, `res_invalid_o`, `res_cc_o` and `cc_wmask_o` keep their values.
- R12: Every valid compare returns a status. An ordered compare following an invalid one returns `res_invalid_o`=0, so the cause can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare request strobe |
| fmt_dbl_i | input | 1 | 0 single, 1 double |
| abs_i | input | 1 | Compare absolute values |
| pred_i | input | 4 | Predicate: [3] signal on quiet NaN, [2] below, [1] equal, [0] unordered |
| cc_i | input | CC_W | Target condition-code index |
| opa_i | input | 1+DP_EXP_W+DP_FRAC_W | First operand |
| opb_i | input | 1+DP_EXP_W+DP_FRAC_W | Second operand |
| res_valid_o | output | 1 | Result strobe |
| res_bit_o | output | 1 | Condition result |
| res_invalid_o | output | 1 | Invalid-operation status |
| res_cc_o | output | CC_W | Index of the written condition bit |
| cc_wmask_o | output | 2**CC_W | One-hot condition-code write mask |

## Verification
The bench builds the unit with a 3-bit exponent and 2-bit fraction for single format and a 4-bit exponent and 3-bit fraction for double format. Every encoding then fits in 6 or 8 bits. All 4096 single pairs and all 65536 double pairs are applied back to back. This covers every zero, denormal, infinity, quiet NaN and signalling NaN against every other value, with the predicate, absolute mode, target index and unused upper bits rotated across the sweep. Expected results come from a signed-integer model of the encodings.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    // predicate mask width: [3] quiet-NaN signals, [2] below, [1] equal, [0] unordered
    localparam int PRED_W = 4;

    typedef struct packed {
        logic below;
        logic equal;
        logic unord;
    } fpcmp_rel_t;
endpackage

// File: rtl/fpcmp_unpack.sv
module fpcmp_unpack #(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    localparam int OPW  = 1 + DP_EXP_W + DP_FRAC_W,
    localparam int SPW  = 1 + SP_EXP_W + SP_FRAC_W,
    localparam int MAGW = DP_EXP_W + DP_FRAC_W,
    localparam int PADW = MAGW - (SP_EXP_W + SP_FRAC_W)
) (
    input  logic [OPW-1:0]  opnd_i,
    input  logic            dbl_i,
    input  logic            abs_i,
    output logic            sign_o,
    output logic [MAGW-1:0] mag_o,
    output logic            nan_o,
    output logic            snan_o
);
    logic                 s_sign;
    logic [SP_EXP_W-1:0]  s_exp;
    logic [SP_FRAC_W-1:0] s_frac;
    logic                 d_sign;
    logic [DP_EXP_W-1:0]  d_exp;
    logic [DP_FRAC_W-1:0] d_frac;
    logic                 s_nan, d_nan;
    logic                 sign_raw;

    assign s_sign = opnd_i[SPW-1];
    assign s_exp  = opnd_i[SPW-2 -: SP_EXP_W];
    assign s_frac = opnd_i[SP_FRAC_W-1:0];
    assign d_sign = opnd_i[OPW-1];
    assign d_exp  = opnd_i[OPW-2 -: DP_EXP_W];
    assign d_frac = opnd_i[DP_FRAC_W-1:0];

    assign s_nan = (&s_exp) && (|s_frac);
    assign d_nan = (&d_exp) && (|d_frac);

    always_comb begin
        if (dbl_i) begin
            sign_raw = d_sign;
            mag_o    = {d_exp, d_frac};
            nan_o    = d_nan;
            snan_o   = d_nan && !d_frac[DP_FRAC_W-1];
        end else begin
            sign_raw = s_sign;
            mag_o    = {{PADW{1'b0}}, s_exp, s_frac};
            nan_o    = s_nan;
            snan_o   = s_nan && !s_frac[SP_FRAC_W-1];
        end
        sign_o = sign_raw && !abs_i;
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAGW = 63
) (
    input  logic            sign_a_i,
    input  logic [MAGW-1:0] mag_a_i,
    input  logic            nan_a_i,
    input  logic            sign_b_i,
    input  logic [MAGW-1:0] mag_b_i,
    input  logic            nan_b_i,
    output fpcmp_rel_t      rel_o
);
    logic both_zero;
    logic unord;
    logic same;

    assign both_zero = (mag_a_i == '0) && (mag_b_i == '0);
    assign unord     = nan_a_i || nan_b_i;
    assign same      = !unord && (both_zero ||
                       ((sign_a_i == sign_b_i) && (mag_a_i == mag_b_i)));

    always_comb begin
        rel_o.unord = unord;
        rel_o.equal = same;
        if (unord || same)
            rel_o.below = 1'b0;
        else if (sign_a_i != sign_b_i)
            rel_o.below = sign_a_i;
        else if (!sign_a_i)
            rel_o.below = mag_a_i < mag_b_i;
        else
            rel_o.below = mag_a_i > mag_b_i;
    end
endmodule

// File: rtl/fpcmp_pick.sv
module fpcmp_pick
    import fpcmp_pkg::*;
(
    input  fpcmp_rel_t        rel_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic              snan_a_i,
    input  logic              snan_b_i,
    output logic              cond_o,
    output logic              invalid_o
);
    assign cond_o = (pred_i[2] && rel_i.below) ||
                    (pred_i[1] && rel_i.equal) ||
                    (pred_i[0] && rel_i.unord);
    assign invalid_o = rel_i.unord && (pred_i[3] || snan_a_i || snan_b_i);
endmodule

// File: rtl/fp_cmp_unit.sv
module fp_cmp_unit
    import fpcmp_pkg::*;
#(
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int CC_W      = 3,
    localparam int OPW  = 1 + DP_EXP_W + DP_FRAC_W,
    localparam int MAGW = DP_EXP_W + DP_FRAC_W,
    localparam int NCC  = 1 << CC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              fmt_dbl_i,
    input  logic              abs_i,
    input  logic [PRED_W-1:0] pred_i,
    input  logic [CC_W-1:0]   cc_i,
    input  logic [OPW-1:0]    opa_i,
    input  logic [OPW-1:0]    opb_i,
    output logic              res_valid_o,
    output logic              res_bit_o,
    output logic              res_invalid_o,
    output logic [CC_W-1:0]   res_cc_o,
    output logic [NCC-1:0]    cc_wmask_o
);
    typedef struct packed {
        logic            vld;
        logic            cond;
        logic            inv;
        logic [CC_W-1:0] cc;
        logic [NCC-1:0]  mask;
    } state_t;

    state_t st_d, st_q;

    logic            sign_a, sign_b;
    logic [MAGW-1:0] mag_a, mag_b;
    logic            nan_a, nan_b, snan_a, snan_b;
    fpcmp_rel_t      rel;
    logic            cond_w, inv_w;
    logic [NCC-1:0]  dec_w;

    fpcmp_unpack #(
        .SP_EXP_W(SP_EXP_W), .SP_FRAC_W(SP_FRAC_W),
        .DP_EXP_W(DP_EXP_W), .DP_FRAC_W(DP_FRAC_W)
    ) i_unpack_a (
        .opnd_i(opa_i), .dbl_i(fmt_dbl_i), .abs_i(abs_i),
        .sign_o(sign_a), .mag_o(mag_a), .nan_o(nan_a), .snan_o(snan_a)
    );

    fpcmp_unpack #(
        .SP_EXP_W(SP_EXP_W), .SP_FRAC_W(SP_FRAC_W),
        .DP_EXP_W(DP_EXP_W), .DP_FRAC_W(DP_FRAC_W)
    ) i_unpack_b (
        .opnd_i(opb_i), .dbl_i(fmt_dbl_i), .abs_i(abs_i),
        .sign_o(sign_b), .mag_o(mag_b), .nan_o(nan_b), .snan_o(snan_b)
    );

    fpcmp_order #(.MAGW(MAGW)) i_order (
        .sign_a_i(sign_a), .mag_a_i(mag_a), .nan_a_i(nan_a),
        .sign_b_i(sign_b), .mag_b_i(mag_b), .nan_b_i(nan_b),
        .rel_o(rel)
    );

    fpcmp_pick i_pick (
        .rel_i(rel), .pred_i(pred_i),
        .snan_a_i(snan_a), .snan_b_i(snan_b),
        .cond_o(cond_w), .invalid_o(inv_w)
    );

    // target index decoder, one line per condition-code bit
    for (genvar g = 0; g < NCC; g++) begin : g_dec
        assign dec_w[g] = (cc_i == CC_W'(g));
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.cond = cond_w;
            st_d.inv  = inv_w;
            st_d.cc   = cc_i;
            st_d.mask = dec_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o   = st_q.vld;
    assign res_bit_o     = st_q.cond;
    assign res_invalid_o = st_q.inv;
    assign res_cc_o      = st_q.cc;
    assign cc_wmask_o    = st_q.mask;
endmodule

// File: rtl/fp_cmp_unit_chk.sv
module fp_cmp_unit_chk #(
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52,
    parameter int CC_W      = 3,
    localparam int OPW = 1 + DP_EXP_W + DP_FRAC_W,
    localparam int NCC = 1 << CC_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            valid_i,
    input logic            fmt_dbl_i,
    input logic [3:0]      pred_i,
    input logic [CC_W-1:0] cc_i,
    input logic [OPW-1:0]  opa_i,
    input logic [OPW-1:0]  opb_i,
    input logic            res_valid_o,
    input logic            res_bit_o,
    input logic            res_invalid_o,
    input logic [CC_W-1:0] res_cc_o,
    input logic [NCC-1:0]  cc_wmask_o
);
    // R9
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_valid_o);
    // R9
    idle_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !res_valid_o);
    // R10
    cc_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (res_cc_o == $past(cc_i)));
    // R10
    mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (($countones(cc_wmask_o) == 1) && cc_wmask_o[res_cc_o]));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_bit_o) && $stable(res_invalid_o) && $stable(cc_wmask_o)));
    // R7
    empty_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i[2:0] == 3'b000) |=> !res_bit_o);
    // R5
    self_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_dbl_i && opa_i == opb_i && !(&opa_i[OPW-2 -: DP_EXP_W]) && pred_i[1])
        |=> res_bit_o);
    // R4
    quiet_signal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && fmt_dbl_i && (&opa_i[OPW-2 -: DP_EXP_W]) && (|opa_i[DP_FRAC_W-1:0]) && pred_i[3])
        |=> res_invalid_o);
    // R4
    invalid_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid_o && $rose(res_invalid_o) |-> res_valid_o);
endmodule

bind fp_cmp_unit fp_cmp_unit_chk #(
    .DP_EXP_W(DP_EXP_W), .DP_FRAC_W(DP_FRAC_W), .CC_W(CC_W)
) i_fp_cmp_unit_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fmt_dbl_i(fmt_dbl_i),
    .pred_i(pred_i), .cc_i(cc_i), .opa_i(opa_i), .opb_i(opb_i),
    .res_valid_o(res_valid_o), .res_bit_o(res_bit_o),
    .res_invalid_o(res_invalid_o), .res_cc_o(res_cc_o), .cc_wmask_o(cc_wmask_o)
);

// File: tb/test_fp_cmp_unit.sv
`timescale 1ns/1ps
module test_fp_cmp_unit;
    localparam int SE = 3, SF = 2, DE = 4, DF = 3, CCW = 3;
    localparam int OPW = 1 + DE + DF;
    localparam int SPW = 1 + SE + SF;
    localparam int NCC = 1 << CCW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic valid_i = 1'b0, fmt_dbl_i = 1'b0, abs_i = 1'b0;
    logic [3:0] pred_i = '0;
    logic [CCW-1:0] cc_i = '0;
    logic [OPW-1:0] opa_i = '0, opb_i = '0;
    logic res_valid_o, res_bit_o, res_invalid_o;
    logic [CCW-1:0] res_cc_o;
    logic [NCC-1:0] cc_wmask_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fp_cmp_unit #(.SP_EXP_W(SE), .SP_FRAC_W(SF), .DP_EXP_W(DE), .DP_FRAC_W(DF), .CC_W(CCW))
    i_fp_cmp_unit (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model derived from the requirements: signed integer keys
    function automatic void model(input int a, input int b, input bit dbl, input int pred,
                                  input bit am, output bit r, output bit inv, output string tag);
        int ew, fw, fa, fb, ea, eb, sa, sb, ka, kb;
        bit na, nb, sna, snb, lt, eq, un;
        ew = dbl ? DE : SE;
        fw = dbl ? DF : SF;
        fa = a & ((1 << fw) - 1);  fb = b & ((1 << fw) - 1);
        ea = (a >> fw) & ((1 << ew) - 1);  eb = (b >> fw) & ((1 << ew) - 1);
        sa = (a >> (ew + fw)) & 1;  sb = (b >> (ew + fw)) & 1;
        na = (ea == (1 << ew) - 1) && fa != 0;
        nb = (eb == (1 << ew) - 1) && fb != 0;
        sna = na && (((fa >> (fw - 1)) & 1) == 0);
        snb = nb && (((fb >> (fw - 1)) & 1) == 0);
        ka = (ea << fw) | fa;  kb = (eb << fw) | fb;
        if (na || nb) begin
            lt = 0; eq = 0; un = 1;
            inv = pred[3] || sna || snb;
            tag = "R3";
        end else begin
            if (sa == 1 && !am) ka = -ka;
            if (sb == 1 && !am) kb = -kb;
            lt = ka < kb; eq = ka == kb; un = 0; inv = 0;
            if (ka == 0 && kb == 0) tag = "R5";
            else if (am) tag = "R8";
            else tag = "R6";
        end
        r = (pred[2] && lt) || (pred[1] && eq) || (pred[0] && un);
    endfunction

    task automatic apply(input int a, input int b, input bit dbl, input int pred,
                         input bit am, input int cc, input string rtag);
        bit r, inv;
        string tag;
        model(a, b, dbl, pred, am, r, inv, tag);
        @(negedge clk);
        valid_i = 1; fmt_dbl_i = dbl; abs_i = am; pred_i = 4'(pred);
        cc_i = CCW'(cc); opa_i = OPW'(a); opb_i = OPW'(b);
        @(posedge clk); #1;
        chk({rtag.len() ? rtag : tag, " R7 result"}, res_bit_o, r);
        chk("R4 invalid", res_invalid_o, inv);
        chk("R9 valid", res_valid_o, 1);
        chk("R10 cc", res_cc_o, cc);
        chk("R10 mask", cc_wmask_o, 1 << cc);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", res_valid_o, 0);
        chk("R1 bit", res_bit_o, 0);
        chk("R1 mask", cc_wmask_o, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk("R1 idle after reset", {res_valid_o, res_bit_o, res_invalid_o, res_cc_o, cc_wmask_o}, 0);

        // single sweep with junk in unused upper bits (R2)
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++) begin
                int junk = (i + 2 * j) & 3;
                apply(i | (junk << SPW), j | (((junk + 1) & 3) << SPW), 0,
                      (i * 5 + j * 3) & 15, ((i >> 1) ^ j) & 1, (i * 3 + j) & 7, "");
            end

        // double sweep
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                apply(i, j, 1, (i * 7 + j * 3) & 15, ((i >> 2) ^ (j >> 1)) & 1,
                      (i + j * 5) & 7, "");

        // R2 directed: upper bits would make a negative double
        apply('hC4, 'h08, 0, 4'b0100, 0, 2, "R2");
        chk("R2 below from low bits only", res_bit_o, 1);

        // R12 invalid then ordered compare clears the cause
        apply('h79, 'h08, 1, 4'b0001, 0, 1, "R12");
        chk("R12 invalid raised", res_invalid_o, 1);
        apply('h10, 'h08, 1, 4'b1010, 0, 5, "R12");
        chk("R12 cause cleared", res_invalid_o, 0);
        chk("R12 status reported", res_valid_o, 1);

        // R11 idle cycle holds results
        apply('h08, 'h10, 1, 4'b0100, 0, 6, "R11");
        @(negedge clk);
        valid_i = 0; pred_i = 4'b0000; cc_i = 3'd0; opa_i = 'h79; opb_i = 'h79;
        @(posedge clk); #1;
        chk("R11 valid low", res_valid_o, 0);
        chk("R11 bit held", res_bit_o, 1);
        chk("R11 cc held", res_cc_o, 6);
        chk("R11 mask held", cc_wmask_o, 1 << 6);
        chk("R11 invalid held", res_invalid_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule